// File: doc/BRIEF.md
# Level-Triggered Input Interrupt Router

This block watches a wide bank of general-purpose inputs, organised as 8-bit byte lanes, and folds them into one interrupt request for a processor. There are eight interrupt channels. Channel `n` always looks at bit `n` of a byte lane, and a per-channel lane-select field picks which lane that is. A per-channel trigger field arms the channel for a high level or a low level on that bit. Two further event sources, fed by neighbouring engines that report completion, share the same pending, mask and status machinery as bits 8 and 9.

Inputs pass through a synchroniser before they are compared. A channel whose condition holds latches a pending bit. The pending bit stays set until software writes a one to the matching bit of the acknowledge register. The status register shows pending ANDed with mask, and the interrupt output is high while any status bit is set. A level that still holds after an acknowledge sets its pending bit again on the following cycle. Software must therefore remove the cause, or mask the channel, before it acknowledges.

Access uses a single write strobe with an address and write data. Read data is a combinational function of the address.

Top module: `gpio_irq_router`

## Requirements
- R1: While reset is asserted and after it is released, the trigger, lane-select and mask registers read zero, nothing is pending, status reads zero and `irq_o` is low.
- R2: A channel whose 3-bit trigger field equals 1 (high level) sets its pending bit while its watched bit is 1.
- R3: A channel whose trigger field equals 2 (low level) sets its pending bit while its watched bit is 0.
- R4: Trigger codes 0 and 3 to 7 leave a channel disarmed: its pending bit never sets, whatever the input level.
- R5: Channel `n` watches `lane_in[8*L+n]`, where L is the 4-bit field at bits [4n+3:4n] of the lane-select register (address 1). The same bit in any other lane has no effect.
- R6: The trigger field of channel `n` sits at bits [3n+2:3n] of the trigger register (address 0). Bits 31:24 of that register read as zero.
- R7: Mask register (address 2) bits 0 to 7 enable the channels and bits 8 and 9 enable the two done sources; bits above 9 read as zero. Status (address 4) reads as pending AND mask. A pending bit latches whether or not it is masked.
- R8: `irq_o` is high exactly when the status value is non-zero.
- R9: Writing to the acknowledge register (address 3) clears each pending bit whose data bit is 1; the clear wins in the cycle of the write. If the level condition still holds, the bit is pending again one cycle later.
- R10: A high `done_evt[k]` in a cycle sets pending bit 8+k at the next clock edge, with no synchroniser.
- R11: An input change shows in the status register after exactly three rising clock edges (two synchroniser stages, then the pending latch).
- R12: A pending bit stays set after its level condition goes away, until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_in | input | NUM_LANES*8 | Watched inputs, lane L at bits [8L+7:8L] |
| done_evt | input | 2 | Completion events from neighbouring engines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 trigger, 1 lane select, 2 mask, 3 acknowledge, 4 status) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench uses the defaults: `NUM_LANES` = 16 and `SYNC_STAGES` = 2. With 16 lanes, every value of the 4-bit lane-select field names a real lane. This lets the bench reach the outermost fields: channel 7 on lane 15 (the top bits of both configuration registers) and lane 0 as a decoy. With two synchroniser stages, the latency has a fixed value of three edges, which the bench checks edge by edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int CH_CNT   = 8;
  localparam int LANE_W   = 8;
  localparam int TRIG_W   = 3;
  localparam int SEL_W    = 4;
  localparam int DONE_CNT = 2;
  localparam int SRC_CNT  = CH_CNT + DONE_CNT;

  localparam logic [TRIG_W-1:0] TRIG_HIGH = 3'd1;
  localparam logic [TRIG_W-1:0] TRIG_LOW  = 3'd2;

  typedef enum logic [2:0] {
    RA_TRIG = 3'd0,
    RA_SEL  = 3'd1,
    RA_MASK = 3'd2,
    RA_ACK  = 3'd3,
    RA_STAT = 3'd4
  } reg_addr_e;

  // Only the two level encodings arm a channel.
  function automatic logic trig_armed(logic [TRIG_W-1:0] code);
    return (code == TRIG_HIGH) || (code == TRIG_LOW);
  endfunction

  function automatic logic level_hit(logic [TRIG_W-1:0] code, logic pin);
    return ((code == TRIG_HIGH) && pin) || ((code == TRIG_LOW) && !pin);
  endfunction

  // Flat position of the watched bit for a channel on a lane.
  function automatic int watch_index(int lane, int chan);
    return lane * LANE_W + chan;
  endfunction
endpackage

// File: rtl/irq_input_sync.sv
module irq_input_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d_in;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/irq_channel.sv
module irq_channel
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LANES = 16,
  parameter int CHAN      = 0
) (
  input  logic [NUM_LANES*LANE_W-1:0] lanes,
  input  logic [TRIG_W-1:0]           trig,
  input  logic [SEL_W-1:0]            lane_sel,
  output logic                        armed,
  output logic                        hit
);
  logic pin;

  always_comb begin
    pin = 1'b0;
    if (int'(lane_sel) < NUM_LANES) pin = lanes[watch_index(int'(lane_sel), CHAN)];
  end

  assign armed = trig_armed(trig);
  assign hit   = level_hit(trig, pin);
endmodule

// File: rtl/irq_pending.sv
module irq_pending
  import gpio_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SRC_CNT-1:0] set_bits,
  input  logic [SRC_CNT-1:0] ack_bits,
  output logic [SRC_CNT-1:0] pend_q
);
  // The acknowledge wins in its own cycle; a held cause sets the bit again one cycle later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else pend_q <= (pend_q | set_bits) & ~ack_bits;
  end
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LANES   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_LANES*LANE_W-1:0] lane_in,
  input  logic [DONE_CNT-1:0]         done_evt,
  input  logic                        reg_wr,
  input  logic [2:0]                  reg_addr,
  input  logic [31:0]                 reg_wdata,
  output logic [31:0]                 reg_rdata,
  output logic                        irq_o
);
  localparam int TRIG_BITS = CH_CNT * TRIG_W;
  localparam int SEL_BITS  = CH_CNT * SEL_W;
  localparam int IN_W      = NUM_LANES * LANE_W;

  logic [TRIG_BITS-1:0] trig_q;
  logic [SEL_BITS-1:0]  sel_q;
  logic [SRC_CNT-1:0]   mask_q;
  logic [IN_W-1:0]      lanes_sync;
  logic [CH_CNT-1:0]    chan_en;
  logic [CH_CNT-1:0]    chan_hit;
  logic [SRC_CNT-1:0]   set_bits;
  logic [SRC_CNT-1:0]   ack_bits;
  logic [SRC_CNT-1:0]   pend_q;
  logic [SRC_CNT-1:0]   status_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= '0;
      sel_q  <= '0;
      mask_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        RA_TRIG: trig_q <= reg_wdata[TRIG_BITS-1:0];
        RA_SEL:  sel_q  <= reg_wdata[SEL_BITS-1:0];
        RA_MASK: mask_q <= reg_wdata[SRC_CNT-1:0];
        default: ;
      endcase
    end
  end

  irq_input_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(lane_in), .d_out(lanes_sync)
  );

  generate
    for (genvar c = 0; c < CH_CNT; c++) begin : g_chan
      irq_channel #(.NUM_LANES(NUM_LANES), .CHAN(c)) u_ch (
        .lanes(lanes_sync),
        .trig(trig_q[c*TRIG_W +: TRIG_W]),
        .lane_sel(sel_q[c*SEL_W +: SEL_W]),
        .armed(chan_en[c]),
        .hit(chan_hit[c])
      );
    end
  endgenerate

  assign set_bits = {done_evt, chan_hit};
  assign ack_bits = (reg_wr && reg_addr == RA_ACK) ? reg_wdata[SRC_CNT-1:0] : '0;

  irq_pending u_pend (
    .clk(clk), .rst_n(rst_n), .set_bits(set_bits), .ack_bits(ack_bits), .pend_q(pend_q)
  );

  assign status_w = pend_q & mask_q;
  assign irq_o    = |status_w;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_TRIG: reg_rdata[TRIG_BITS-1:0] = trig_q;
      RA_SEL:  reg_rdata[SEL_BITS-1:0]  = sel_q;
      RA_MASK: reg_rdata[SRC_CNT-1:0]   = mask_q;
      RA_STAT: reg_rdata[SRC_CNT-1:0]   = status_w;
      default: ;
    endcase
  end
endmodule

// File: rtl/gpio_irq_router_chk.sv
module gpio_irq_router_chk
  import gpio_irq_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic [SRC_CNT-1:0]  pend_q,
  input logic [SRC_CNT-1:0]  ack_bits,
  input logic [DONE_CNT-1:0] done_evt,
  input logic [CH_CNT-1:0]   chan_en
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |-> pend_q == '0);

  // R9
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_bits != '0) |=> (pend_q & $past(ack_bits)) == '0);

  // R12
  pending_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (pend_q & $past(pend_q & ~ack_bits)) == $past(pend_q & ~ack_bits));

  // R10
  done_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((done_evt & ~ack_bits[SRC_CNT-1:CH_CNT]) != '0) |=>
      (pend_q[SRC_CNT-1:CH_CNT] & $past(done_evt & ~ack_bits[SRC_CNT-1:CH_CNT]))
        == $past(done_evt & ~ack_bits[SRC_CNT-1:CH_CNT]));

  // R4
  disarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((pend_q[CH_CNT-1:0] & ~$past(pend_q[CH_CNT-1:0])) & ~$past(chan_en)) == '0);
endmodule

bind gpio_irq_router gpio_irq_router_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pend_q(pend_q), .ack_bits(ack_bits),
  .done_evt(done_evt), .chan_en(chan_en)
);

// File: tb/sim_gpio_irq_router.sv
`timescale 1ns/1ps
module sim_gpio_irq_router;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] lane_in = '0;
  logic [1:0]   done_evt = '0;
  logic         reg_wr = 1'b0;
  logic [2:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         irq_o;
  int checks = 0;
  int fails  = 0;
  logic [31:0] v;

  always #10 clk = ~clk;

  gpio_irq_router u0 (
    .clk(clk), .rst_n(rst_n), .lane_in(lane_in), .done_evt(done_evt),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rd(0, v); chk("R1 trig", v, 0);
    rd(1, v); chk("R1 sel", v, 0);
    rd(2, v); chk("R1 mask", v, 0);
    rd(4, v); chk("R1 status", v, 0);
    chk("R1 irq", {31'b0, irq_o}, 0);
  endtask

  task automatic t_regmap;
    wr(0, 32'hFFFF_FFFF); rd(0, v); chk("R6 trig width", v, 32'h00FF_FFFF);
    wr(1, 32'hA5C3_1E97); rd(1, v); chk("R5 sel readback", v, 32'hA5C3_1E97);
    wr(2, 32'hFFFF_FFFF); rd(2, v); chk("R7 mask width", v, 32'h0000_03FF);
    wr(0, 0); wr(1, 0); wr(2, 0); wr(3, 32'h3FF);
  endtask

  task automatic t_high_level;
    // channel 2 high level (bits 8:6 = 1), lane 5 (bits 11:8 = 5)
    wr(0, 32'd1 << 6); wr(1, 32'd5 << 8); wr(2, 32'h004);
    lane_in[2] = 1'b1;                          // decoy on lane 0
    idle(5); rd(4, v); chk("R5 other lane ignored", v, 0);
    lane_in[8*5+2] = 1'b1;
    idle(2); rd(4, v); chk("R11 not yet after two edges", v, 0);
    idle(1); rd(4, v); chk("R2/R11 set after three edges", v, 32'h004);
    chk("R8 irq high", {31'b0, irq_o}, 1);
    wr(3, 32'h004); rd(4, v); chk("R9 cleared in ack cycle", v, 0);
    idle(1); rd(4, v); chk("R9 set again while level holds", v, 32'h004);
    lane_in[8*5+2] = 1'b0; lane_in[2] = 1'b0;
    idle(5); rd(4, v); chk("R12 held after level gone", v, 32'h004);
    wr(3, 32'h004); idle(2); rd(4, v); chk("R9 stays clear", v, 0);
    chk("R8 irq low", {31'b0, irq_o}, 0);
  endtask

  task automatic t_low_level;
    // channel 7 low level (bits 23:21 = 2), lane 15 (bits 31:28)
    lane_in[8*15+7] = 1'b1;
    wr(1, 32'd15 << 28); wr(0, 32'd2 << 21); wr(2, 32'h080);
    idle(4); rd(4, v); chk("R3 quiet while high", v, 0);
    lane_in[8*15+7] = 1'b0;
    idle(3); rd(4, v); chk("R3 set when low", v, 32'h080);
    lane_in[8*15+7] = 1'b1; idle(4);
    wr(3, 32'h080); idle(2); rd(4, v); chk("R3 clear after ack", v, 0);
  endtask

  task automatic t_disarmed;
    wr(1, 0); wr(2, 32'h001); wr(3, 32'h3FF);
    for (int code = 0; code < 8; code++) begin
      if (code == 1 || code == 2) continue;
      wr(0, code);
      lane_in[0] = 1'b1; idle(5);
      lane_in[0] = 1'b0; idle(5);
      rd(4, v); chk($sformatf("R4 code %0d", code), v, 0);
    end
  endtask

  task automatic t_mask;
    // channel 1 high level on lane 0, masked off
    wr(0, 32'd1 << 3); wr(1, 0); wr(2, 0);
    lane_in[1] = 1'b1; idle(4); lane_in[1] = 1'b0; idle(4);
    rd(4, v); chk("R7 masked status zero", v, 0);
    chk("R8 irq low when masked", {31'b0, irq_o}, 0);
    wr(2, 32'h002); rd(4, v); chk("R7 latched while masked", v, 32'h002);
    chk("R8 irq after unmask", {31'b0, irq_o}, 1);
    wr(3, 32'h002); wr(0, 0);
  endtask

  task automatic t_done;
    wr(2, 32'h100); wr(3, 32'h3FF);
    @(negedge clk); done_evt = 2'b01;
    @(negedge clk); done_evt = 2'b00;
    rd(4, v); chk("R10 done0 one edge", v, 32'h100);
    done_evt = 2'b10; @(negedge clk); done_evt = 2'b00;
    rd(4, v); chk("R7 done1 masked", v, 32'h100);
    wr(2, 32'h300); rd(4, v); chk("R10 done1 latched", v, 32'h300);
    wr(3, 32'h300); rd(4, v); chk("R9 done cleared", v, 0);
    chk("R8 irq low", {31'b0, irq_o}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    t_reset;
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    t_reset;
    t_regmap;
    t_high_level;
    t_low_level;
    t_disarmed;
    t_mask;
    t_done;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule